// File: doc/BRIEF.md
# Serial Boot PROM Word Reader

This block fetches 16-bit words from a parallel boot PROM through a narrow serial link, for use while a chip is still coming out of reset. The host side presents a 21-bit word address (4 MBytes of byte space in a 16-bit-wide device) with a one-cycle request. The block then shifts the address out, MSB first, to a serial-to-parallel register on the board. It strobes that register to latch the address onto the PROM pins and waits a programmable number of serial periods for the PROM access. Next it pulses a load strobe to a parallel-to-serial register on the board and shifts the sixteen returned data bits in, again MSB first. The assembled word is handed back with a one-cycle valid pulse.

The serial clock is derived from the core clock by a programmable integer divider, selectable from one half down to one sixteenth of the core rate. The divider and wait settings are sampled when a request is accepted, so a change made during a transfer only affects the next one. A request is taken only while the busy output is low.

Top module: `boot_prom_serial_reader`

## Requirements
- R1: After reset, busy, rd_valid, ser_clk, addr_latch and data_load are all low.
- R2: While busy, ser_clk has a period of N core cycles, where N = max(div_sel,1)+1 (N ranges 2..16). Each period is low for floor(N/2) core cycles and then high for the remaining cycles. Every serial slot below lasts exactly one period.
- R3: A request (req high at a rising core clock edge) is accepted only when busy is low, and busy is high from the next cycle. A request made while busy is ignored: it starts no transfer and produces no extra rd_valid.
- R4: The 21 address bits leave on ser_addr_out MSB first, one per serial period, and each bit is stable across the rising edge of ser_clk in its period.
- R5: addr_latch is high for exactly the one serial period that follows the last address bit.
- R6: After the latch period come wait_sel (0..15) idle serial periods, then data_load is high for one serial period. The rising ser_clk edge of the load period is (wait_sel+1)*N core cycles after that of the latch period.
- R7: In the 16 serial periods after the load period, ser_data_in is sampled in the last core cycle before each rising ser_clk edge. The first sampled bit becomes rd_data bit 15.
- R8: rd_valid is high for exactly one core cycle, with rd_data holding the word and busy already low. It rises (39+wait_sel)*N core cycles after the accepting edge.
- R9: div_sel and wait_sel are captured at acceptance, and changing them while busy has no effect on the running transfer.
- R10: While busy is low, ser_clk, addr_latch, data_load and ser_addr_out stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 4 | Serial clock divider select; period N = max(div_sel,1)+1 core cycles |
| wait_sel | input | 4 | Number of serial periods of PROM access wait |
| req | input | 1 | Read request, taken when busy is low |
| req_addr | input | 21 | PROM word address |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the fetched word |
| rd_data | output | 16 | Fetched PROM word |
| ser_clk | output | 1 | Serial link clock |
| ser_addr_out | output | 1 | Serial address stream to the board register |
| addr_latch | output | 1 | Latch strobe for the board address register |
| data_load | output | 1 | Parallel-load strobe for the board data register |
| ser_data_in | input | 1 | Serial data stream from the board register |

## Verification
The in-design assertions check on every cycle that the serial outputs stay quiet when idle and that the strobes and the valid pulse never overlap. They also check that valid lasts one cycle, that the load strobe only follows the latch or wait phase, and that the captured divider stays stable during a transfer. Period length, the high/low split, the latch-to-load distance, total latency and the bit order of address and data can only be shown by the bench. It models both board shift registers and sweeps every divider setting against several wait settings and address patterns, computing the expected cycle counts arithmetically.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_LATCH,
      PH_WAIT,
      PH_LOAD,
      PH_DATA
   } phase_t;
endpackage

// File: rtl/bsr_clkgen.sv
module bsr_clkgen #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] ratio_m1,
   output logic             ser_clk,
   output logic             sample_stb,
   output logic             slot_end
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W:0]   half_w;
   logic [DIV_W:0]   cnt_w;

   assign half_w     = ({1'b0, ratio_m1} + 1'b1) >> 1;
   assign cnt_w      = {1'b0, cnt};
   assign ser_clk    = run && (cnt_w >= half_w);
   assign sample_stb = run && ((cnt_w + 1'b1) == half_w);
   assign slot_end   = run && (cnt == ratio_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || slot_end)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= ratio_m1) && (ratio_m1 != '0));
endmodule

// File: rtl/bsr_seq.sv
module bsr_seq
   import bsr_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 16,
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              slot_end,
   input  logic [WAIT_W-1:0] wait_q,
   output phase_t            phase,
   output logic              busy,
   output logic              done
);
   localparam int MAXC  = (ADDR_W > DATA_W) ?
                          ((ADDR_W > (1 << WAIT_W)) ? ADDR_W : (1 << WAIT_W)) :
                          ((DATA_W > (1 << WAIT_W)) ? DATA_W : (1 << WAIT_W));
   localparam int IDX_W = $clog2(MAXC + 1);
   localparam logic [IDX_W-1:0] A_LAST = IDX_W'(ADDR_W - 1);
   localparam logic [IDX_W-1:0] D_LAST = IDX_W'(DATA_W - 1);

   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] w_last;

   assign w_last = IDX_W'(wait_q) - 1'b1;
   assign busy   = (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (phase == PH_IDLE) begin
            if (start) begin
               phase <= PH_ADDR;
               idx   <= '0;
            end
         end else if (slot_end) begin
            unique case (phase)
               PH_ADDR: begin
                  if (idx == A_LAST) begin
                     phase <= PH_LATCH;
                     idx   <= '0;
                  end else
                     idx <= idx + 1'b1;
               end
               PH_LATCH: begin
                  phase <= (wait_q == '0) ? PH_LOAD : PH_WAIT;
                  idx   <= '0;
               end
               PH_WAIT: begin
                  if (idx == w_last) begin
                     phase <= PH_LOAD;
                     idx   <= '0;
                  end else
                     idx <= idx + 1'b1;
               end
               PH_LOAD: begin
                  phase <= PH_DATA;
                  idx   <= '0;
               end
               PH_DATA: begin
                  if (idx == D_LAST) begin
                     phase <= PH_IDLE;
                     idx   <= '0;
                     done  <= 1'b1;
                  end else
                     idx <= idx + 1'b1;
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end

   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   load_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOAD && $past(phase) != PH_LOAD) |->
         ($past(phase) == PH_LATCH || $past(phase) == PH_WAIT));

   // R5
   latch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LATCH && $past(phase) != PH_LATCH) |-> $past(phase) == PH_ADDR);
endmodule

// File: rtl/bsr_shift.sv
module bsr_shift
   import bsr_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr_in,
   input  phase_t            phase,
   input  logic              slot_end,
   input  logic              sample_stb,
   input  logic              ser_in,
   output logic              ser_out,
   output logic [DATA_W-1:0] data
);
   logic [ADDR_W-1:0] areg;

   assign ser_out = (phase == PH_ADDR) && areg[ADDR_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         areg <= '0;
      else if (start)
         areg <= addr_in;
      else if (phase == PH_ADDR && slot_end)
         areg <= {areg[ADDR_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data <= '0;
      else if (phase == PH_DATA && sample_stb)
         data <= {data[DATA_W-2:0], ser_in};
   end

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_ADDR && $past(phase) == PH_ADDR && !$past(slot_end)) |-> $stable(ser_out));
endmodule

// File: rtl/boot_prom_serial_reader.sv
module boot_prom_serial_reader
   import bsr_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 16,
   parameter int DIV_W  = 4,
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_sel,
   input  logic [WAIT_W-1:0] wait_sel,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              busy,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              ser_clk,
   output logic              ser_addr_out,
   output logic              addr_latch,
   output logic              data_load,
   input  logic              ser_data_in
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (WAIT_W < 1) begin : g_bad_wait
         $error("WAIT_W must be at least 1");
      end
   endgenerate

   phase_t            phase;
   logic              accept;
   logic [DIV_W-1:0]  ratio_q;
   logic [WAIT_W-1:0] wait_q;
   logic              sample_stb;
   logic              slot_end;

   assign accept     = req && !busy;
   assign addr_latch = (phase == PH_LATCH);
   assign data_load  = (phase == PH_LOAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= DIV_W'(1);
         wait_q  <= '0;
      end else if (accept) begin
         ratio_q <= (div_sel == '0) ? DIV_W'(1) : div_sel;
         wait_q  <= wait_sel;
      end
   end

   bsr_clkgen #(.DIV_W(DIV_W)) u_clk (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (busy),
      .ratio_m1   (ratio_q),
      .ser_clk    (ser_clk),
      .sample_stb (sample_stb),
      .slot_end   (slot_end)
   );

   bsr_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .slot_end (slot_end),
      .wait_q   (wait_q),
      .phase    (phase),
      .busy     (busy),
      .done     (rd_valid)
   );

   bsr_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shf (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .addr_in    (req_addr),
      .phase      (phase),
      .slot_end   (slot_end),
      .sample_stb (sample_stb),
      .ser_in     (ser_data_in),
      .ser_out    (ser_addr_out),
      .data       (rd_data)
   );

   // R3
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy) |=> busy);

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(ratio_q) && $stable(wait_q)));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(ser_clk || addr_latch || data_load || ser_addr_out));

   // R8
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_latch, data_load, rd_valid}));

   // R8
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !busy);
endmodule

// File: tb/sim_boot_prom_serial_reader.sv
module sim_boot_prom_serial_reader;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  div_sel = '0;
   logic [3:0]  wait_sel = '0;
   logic        req = 1'b0;
   logic [20:0] req_addr = '0;
   logic        busy, rd_valid, ser_clk, ser_addr_out, addr_latch, data_load;
   logic [15:0] rd_data;
   logic        ser_data_in;

   int n_chk = 0;
   int n_bad = 0;

   // board register models
   logic [20:0] sh = '0;
   logic [20:0] cap_addr = '0;
   logic [15:0] dsh = '0;
   logic        sclk_prev = 1'b0;
   int          cyc = 0;
   int          last_rise = 0;
   bit          have_rise = 1'b0;
   int          hi_cnt = 0;
   int          clk_err = 0;
   int          latch_t = 0;
   int          load_t = 0;
   int          exp_n = 2;
   int          exp_hi = 1;

   assign ser_data_in = dsh[15];

   always #(CLK_PERIOD/2) clk = ~clk;

   boot_prom_serial_reader u0 (
      .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .wait_sel(wait_sel),
      .req(req), .req_addr(req_addr), .busy(busy), .rd_valid(rd_valid),
      .rd_data(rd_data), .ser_clk(ser_clk), .ser_addr_out(ser_addr_out),
      .addr_latch(addr_latch), .data_load(data_load), .ser_data_in(ser_data_in)
   );

   function automatic logic [15:0] word_of(input logic [20:0] a);
      return a[15:0] ^ 16'h5AC3 ^ {a[20:16], 11'h0};
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!busy) have_rise = 1'b0;
      if (ser_clk) hi_cnt++;
      if (!ser_clk && sclk_prev) begin
         if (hi_cnt != exp_hi) clk_err++;
         hi_cnt = 0;
      end
      if (ser_clk && !sclk_prev) begin
         if (have_rise && (cyc - last_rise) != exp_n) clk_err++;
         have_rise = 1'b1;
         last_rise = cyc;
         if (addr_latch) begin
            cap_addr <= sh;
            latch_t = cyc;
         end else if (data_load) begin
            dsh <= word_of(cap_addr);
            load_t = cyc;
         end else begin
            sh  <= {sh[19:0], ser_addr_out};
            dsh <= {dsh[14:0], 1'b0};
         end
      end
      sclk_prev = ser_clk;
   end

   task automatic run_txn(input logic [20:0] addr, input logic [3:0] dv,
                          input logic [3:0] wt, input bit interfere);
      int cycles;
      int t_exp;
      exp_n  = ((dv == 0) ? 1 : int'(dv)) + 1;
      exp_hi = exp_n - exp_n / 2;
      clk_err = 0;
      t_exp = (39 + int'(wt)) * exp_n;
      @(negedge clk);
      div_sel = dv; wait_sel = wt; req_addr = addr; req = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0;
      // R9: change settings mid-transfer
      div_sel = ~dv; wait_sel = ~wt;
      check(busy == 1'b1, "R3 busy after accept", busy, 1);
      if (interfere) begin
         req = 1'b1; req_addr = ~addr;
      end
      cycles = 0;
      while (1) begin
         @(posedge clk);
         cycles++;
         @(negedge clk);
         if (cycles == 5) req = 1'b0;
         if (rd_valid || cycles > 2000) break;
      end
      check(cycles == t_exp, "R8 latency", cycles, t_exp);
      check(busy == 1'b0, "R8 busy low with valid", busy, 0);
      check(rd_data == word_of(addr), "R7 data word", rd_data, word_of(addr));
      check(cap_addr == addr, "R4 address bits", cap_addr, addr);
      check((load_t - latch_t) == (int'(wt) + 1) * exp_n, "R6 latch to load",
            load_t - latch_t, (int'(wt) + 1) * exp_n);
      check(clk_err == 0, "R2 serial clock shape", clk_err, 0);
      @(negedge clk);
      check(rd_valid == 1'b0, "R8 valid one cycle", rd_valid, 0);
      repeat (2) @(negedge clk);
      check(busy == 1'b0, "R3 no start while busy", busy, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int k;
      int wl [3];
      logic [20:0] a;
      wl[0] = 0; wl[1] = 5; wl[2] = 15;
      repeat (3) @(negedge clk);
      // R1
      check({busy, rd_valid, ser_clk, addr_latch, data_load} == 5'b0,
            "R1 reset outputs", {busy, rd_valid, ser_clk, addr_latch, data_load}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R10
      check({ser_clk, addr_latch, data_load, ser_addr_out} == 4'b0,
            "R10 idle quiet", {ser_clk, addr_latch, data_load, ser_addr_out}, 0);
      k = 0;
      for (int d = 0; d < 16; d++) begin
         for (int wi = 0; wi < 3; wi++) begin
            for (int r = 0; r < 2; r++) begin
               if (k % 5 == 0)      a = 21'h1FFFFF;
               else if (k % 5 == 1) a = 21'h000000;
               else                 a = 21'((k * 24593) ^ 21'h15A5A5);
               run_txn(a, 4'(d), 4'(wl[wi]), (k % 2) == 1);
               k++;
            end
         end
      end
      // R10
      check({ser_clk, addr_latch, data_load, ser_addr_out} == 4'b0,
            "R10 idle quiet at end", {ser_clk, addr_latch, data_load, ser_addr_out}, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule